// File: doc/BRIEF.md
# VBI Framing Code Detector

This block sits behind a bit slicer on one line of the vertical blanking interval. Each cycle with `bit_vld_i` high it takes one sliced bit. It slides the bit through a window of up to 24 bits and compares the newest bits with the framing code of the standard chosen for the current line. The comparison counts the bits that differ and accepts the code when that count is within the allowed error limit. Once the code is accepted, the following bits are packed into bytes, least significant bit first. Each complete byte is emitted with a single-cycle strobe. A line-end pulse stops byte output and arms the detector for the next line.

The standard selector picks the code value, the code length and whether mismatched bits may be tolerated. Three selections take their code from a programmable input, which allows formats whose code is not fixed. The control is a two-state machine. `ST_HUNT` searches for the code. The transition "code hit" moves it to `ST_COLLECT`, where bytes are assembled. The transition "line end" returns it from either state to `ST_HUNT`.

Top module: `vbi_frame_detect`

## Requirements
- R1: After reset, `found_o` and `byte_vld_o` are low and the block is hunting.
- R2: The selector `line_std_i` picks the framing code as follows:

  | Value | Code | Length |
  |---|---|---|
  | 0 | 0x27 | 8 |
  | 1 | 3'b001 | 3 |
  | 2 | 0x9951 | 16 |
  | 3 | 0x1E3C1F | 24 |
  | 4 | `prog_code_i[7:0]` | 8 |
  | 5 | `prog_code_i[15:0]` | 16 |
  | 6 | `prog_code_i[23:0]` | 24 |

  The first received code bit is compared with the code's most significant bit.
- R3: For selections 0, 2, 3, 4, 5 and 6, the code is accepted when the number of differing bits is at most `err_limit_i`.
- R4: For selection 1, the code is accepted only on an exact match, whatever `err_limit_i` is.
- R5: After acceptance, `found_o` is high from the cycle after the last code bit. Every eight further valid bits produce one `byte_o` with a one-cycle `byte_vld_o`. The earliest of the eight bits lands in bit 0 of the byte.
- R6: `line_end_i` returns the block to hunting. In the next cycle `found_o` is low. A partially assembled byte is discarded, and a bit presented in the same cycle as `line_end_i` is ignored.
- R7: A code is searched only after at least its length in valid bits has arrived since the start of the line. If no code is accepted before the line ends, no byte is output and `found_o` stays low.
- R8: Selection 7 never accepts a code.
- R9: Cycles with `bit_vld_i` low change neither the search nor the byte assembly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_std_i | input | 3 | Standard selection for the current line |
| prog_code_i | input | 24 | Programmable framing code |
| err_limit_i | input | 3 | Accepted number of mismatched code bits |
| bit_vld_i | input | 1 | Sliced bit strobe |
| bit_i | input | 1 | Sliced bit |
| line_end_i | input | 1 | End of the current line |
| byte_o | output | 8 | Assembled data byte |
| byte_vld_o | output | 1 | Byte strobe, one cycle |
| found_o | output | 1 | Framing code accepted on this line |

## Verification
The assertions assume that `line_std_i`, `prog_code_i` and `err_limit_i` hold steady for the whole line. They also assume that `line_end_i` is a single-cycle pulse. The stimulus changes the selector and the code only in the idle cycles around a line-end pulse, and it pulses line end for exactly one cycle. Bits arrive with idle gaps in between, and one line ends with a bit and the line-end pulse in the same cycle.

// File: rtl/vbi_fc_pkg.sv
package vbi_fc_pkg;
    typedef enum logic [2:0] {
        STD_TT    = 3'd0,
        STD_CC    = 3'd1,
        STD_VPS   = 3'd2,
        STD_WSS   = 3'd3,
        STD_PRG8  = 3'd4,
        STD_PRG16 = 3'd5,
        STD_PRG24 = 3'd6,
        STD_OFF   = 3'd7
    } std_e;

    typedef enum logic {
        ST_HUNT    = 1'b0,
        ST_COLLECT = 1'b1
    } state_e;
endpackage

// File: rtl/vbi_code_table.sv
module vbi_code_table
    import vbi_fc_pkg::*;
#(
    parameter int CODE_W = 24,
    localparam int LEN_W = $clog2(CODE_W + 1)
) (
    input  std_e              std_i,
    input  logic [CODE_W-1:0] prog_i,
    output logic [CODE_W-1:0] code_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              tol_o,
    output logic              en_o
);
    always_comb begin
        code_o = '0;
        len_o  = '0;
        tol_o  = 1'b1;
        en_o   = 1'b1;
        unique case (std_i)
            STD_TT:    begin code_o = CODE_W'(24'h000027); len_o = LEN_W'(8);  end
            STD_CC:    begin code_o = CODE_W'(24'h000001); len_o = LEN_W'(3); tol_o = 1'b0; end
            STD_VPS:   begin code_o = CODE_W'(24'h009951); len_o = LEN_W'(16); end
            STD_WSS:   begin code_o = CODE_W'(24'h1E3C1F); len_o = LEN_W'(24); end
            STD_PRG8:  begin code_o = CODE_W'(prog_i[7:0]);  len_o = LEN_W'(8);  end
            STD_PRG16: begin code_o = CODE_W'(prog_i[15:0]); len_o = LEN_W'(16); end
            STD_PRG24: begin code_o = prog_i;                len_o = LEN_W'(24); end
            STD_OFF:   begin en_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/vbi_code_match.sv
module vbi_code_match #(
    parameter int CODE_W = 24,
    parameter int ERR_W  = 3,
    localparam int LEN_W = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              tol_i,
    input  logic              en_i,
    input  logic [ERR_W-1:0]  limit_i,
    output logic              hit_o
);
    logic [CODE_W-1:0] win_q, win_d, mask;
    logic [LEN_W-1:0]  fill_q, fill_d;
    logic [ERR_W-1:0]  limit;
    int                diff;

    assign win_d  = {win_q[CODE_W-2:0], bit_i};
    assign fill_d = (fill_q == LEN_W'(CODE_W)) ? fill_q : fill_q + 1'b1;
    assign limit  = tol_i ? limit_i : '0;

    always_comb begin
        for (int i = 0; i < CODE_W; i++) begin
            mask[i] = (i < int'(len_i));
        end
    end

    assign diff  = $countones((win_d ^ code_i) & mask);
    assign hit_o = shift_i && en_i && (fill_d >= len_i) && (diff <= int'(limit));

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (shift_i) begin
            win_q  <= win_d;
            fill_q <= fill_d;
        end
    end
endmodule

// File: rtl/vbi_frame_detect.sv
module vbi_frame_detect
    import vbi_fc_pkg::*;
#(
    parameter int CODE_W = 24,
    parameter int ERR_W  = 3,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        line_std_i,
    input  logic [CODE_W-1:0] prog_code_i,
    input  logic [ERR_W-1:0]  err_limit_i,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic              line_end_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              found_o
);
    localparam int LEN_W = $clog2(CODE_W + 1);
    localparam int CNT_W = $clog2(BYTE_W);

    state_e              state_q, state_d;
    logic [CODE_W-1:0]   code;
    logic [LEN_W-1:0]    len;
    logic                tol, en, hit, shift;
    logic [BYTE_W-1:0]   acc_q, acc_d;
    logic [CNT_W-1:0]    cnt_q;

    vbi_code_table #(.CODE_W(CODE_W)) u_table (
        .std_i  (std_e'(line_std_i)),
        .prog_i (prog_code_i),
        .code_o (code),
        .len_o  (len),
        .tol_o  (tol),
        .en_o   (en)
    );

    assign shift = bit_vld_i && !line_end_i && (state_q == ST_HUNT);

    vbi_code_match #(.CODE_W(CODE_W), .ERR_W(ERR_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (line_end_i),
        .shift_i (shift),
        .bit_i   (bit_i),
        .code_i  (code),
        .len_i   (len),
        .tol_i   (tol),
        .en_i    (en),
        .limit_i (err_limit_i),
        .hit_o   (hit)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:    if (line_end_i) state_d = ST_HUNT;
                        else if (hit)   state_d = ST_COLLECT;
            ST_COLLECT: if (line_end_i) state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_d;
    end

    assign found_o = (state_q == ST_COLLECT);
    assign acc_d   = {bit_i, acc_q[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            cnt_q      <= '0;
            byte_o     <= '0;
            byte_vld_o <= 1'b0;
        end else begin
            byte_vld_o <= 1'b0;
            if (line_end_i || state_q != ST_COLLECT) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else if (bit_vld_i) begin
                acc_q <= acc_d;
                if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                    byte_o     <= acc_d;
                    byte_vld_o <= 1'b1;
                    cnt_q      <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vbi_fc_chk.sv
module vbi_fc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] line_std_i,
    input logic       bit_vld_i,
    input logic       line_end_i,
    input logic       byte_vld_o,
    input logic       found_o
);
    assert_byte_needs_found_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> found_o);

    assert_end_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        line_end_i |=> (!found_o && !byte_vld_o));

    assert_found_after_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(found_o) |-> $past(bit_vld_i));

    assert_idle_no_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld_i |=> !byte_vld_o);

    assert_off_never_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_std_i == 3'd7 && !found_o) |=> !found_o);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!found_o && !byte_vld_o));
endmodule

bind vbi_frame_detect vbi_fc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_std_i (line_std_i),
    .bit_vld_i  (bit_vld_i),
    .line_end_i (line_end_i),
    .byte_vld_o (byte_vld_o),
    .found_o    (found_o)
);

// File: tb/sim_vbi_frame_detect.sv
`timescale 1ns/1ps
module sim_vbi_frame_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  line_std_i = '0;
    logic [23:0] prog_code_i = '0;
    logic [2:0]  err_limit_i = '0;
    logic        bit_vld_i = 1'b0;
    logic        bit_i = 1'b0;
    logic        line_end_i = 1'b0;
    logic [7:0]  byte_o;
    logic        byte_vld_o;
    logic        found_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [7:0] expq[$];
    logic bitq[$];

    always #5 clk = ~clk;

    vbi_frame_detect u0 (
        .clk(clk), .rst_n(rst_n), .line_std_i(line_std_i), .prog_code_i(prog_code_i),
        .err_limit_i(err_limit_i), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
        .line_end_i(line_end_i), .byte_o(byte_o), .byte_vld_o(byte_vld_o), .found_o(found_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference code table taken from R2, R3, R4, R8
    task automatic ref_code(input int s, input logic [23:0] pc,
                            output logic [23:0] c, output int l, output bit tol, output bit en);
        tol = 1'b1; en = 1'b1; c = '0; l = 0;
        case (s)
            0: begin c = 24'h27;     l = 8;  end
            1: begin c = 24'h1;      l = 3;  tol = 1'b0; end
            2: begin c = 24'h9951;   l = 16; end
            3: begin c = 24'h1E3C1F; l = 24; end
            4: begin c = {16'h0, pc[7:0]};  l = 8;  end
            5: begin c = {8'h0, pc[15:0]};  l = 16; end
            6: begin c = pc;                l = 24; end
            default: en = 1'b0;
        endcase
    endtask

    task automatic add_bits(input logic [23:0] v, input int n, input bit msb_first);
        for (int i = 0; i < n; i++) bitq.push_back(msb_first ? v[n-1-i] : v[i]);
    endtask

    task automatic add_line(input logic [23:0] code, input int l, input logic [23:0] flip,
                            input logic [7:0] d0, input int nbytes, input int extra);
        for (int i = 0; i < 12; i++) bitq.push_back(i % 2 == 0);
        add_bits(code ^ flip, l, 1'b1);
        for (int k = 0; k < nbytes; k++) add_bits({16'h0, d0 + 8'(k * 37)}, 8, 1'b0);
        add_bits(24'h5, extra, 1'b0);
    endtask

    // driver with reference model; pushes expected bytes to the scoreboard
    task automatic run_line(input int s, input logic [23:0] pc, input int lim, input bit end_with_bit);
        logic [23:0] c, w;
        int l, fill, cnt, mism;
        bit tol, en, hit;
        logic [7:0] acc;
        w = '0; fill = 0; hit = 1'b0; cnt = 0; acc = '0;
        ref_code(s, pc, c, l, tol, en);
        @(negedge clk);
        line_std_i = 3'(s); prog_code_i = pc; err_limit_i = 3'(lim);
        for (int i = 0; i < bitq.size(); i++) begin
            bit last;
            last = end_with_bit && (i == bitq.size() - 1);
            @(negedge clk);
            bit_vld_i = 1'b1; bit_i = bitq[i]; line_end_i = last;
            if (!last) begin
                if (!hit) begin
                    w = {w[22:0], bitq[i]};
                    if (fill < 24) fill++;
                    mism = 0;
                    for (int j = 0; j < l; j++) if (w[j] != c[j]) mism++;
                    if (en && fill >= l && mism <= (tol ? lim : 0)) hit = 1'b1;
                end else begin
                    acc = {bitq[i], acc[7:1]};
                    cnt++;
                    if (cnt == 8) begin expq.push_back(acc); cnt = 0; end
                end
            end
            if (i % 5 == 4 && !last) begin
                @(negedge clk);
                bit_vld_i = 1'b0;
            end
        end
        @(negedge clk);
        bit_vld_i = 1'b0;
        if (!end_with_bit) begin
            @(negedge clk);
            chk(found_o == hit, "R7 found before line end", found_o, hit);
            line_end_i = 1'b1;
            @(negedge clk);
        end
        line_end_i = 1'b0;
        chk(found_o == 1'b0, "R6 found cleared by line end", found_o, 0);
        @(negedge clk);
        chk(expq.size() == 0, "R5 all expected bytes seen", expq.size(), 0);
        chk(byte_vld_o == 1'b0, "R6 no byte after line end", byte_vld_o, 0);
        bitq.delete();
        expq.delete();
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && byte_vld_o) begin
            if (expq.size() == 0) chk(1'b0, "R5 unexpected byte", byte_o, 0);
            else begin
                logic [7:0] e;
                e = expq.pop_front();
                chk(byte_o == e, "R5 byte value", byte_o, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(found_o == 1'b0 && byte_vld_o == 1'b0, "R1 reset state", {found_o, byte_vld_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(found_o == 1'b0, "R1 hunting after reset", found_o, 0);
        // R2 fixed 8-bit code, exact
        add_line(24'h27, 8, 24'h0, 8'hA5, 3, 0);       run_line(0, 24'h0, 0, 1'b0);
        // R4 short code exact
        add_line(24'h1, 3, 24'h0, 8'h3C, 2, 0);        run_line(1, 24'h0, 0, 1'b0);
        // R4 flipped short code, large limit, trailing ones
        add_line(24'h1, 3, 24'h4, 8'hFF, 0, 0);
        add_bits(24'hFFFF, 16, 1'b1);                  run_line(1, 24'h0, 7, 1'b0);
        // R3 one mismatch tolerated
        add_line(24'h9951, 16, 24'h0100, 8'h12, 2, 0); run_line(2, 24'h0, 1, 1'b0);
        // R3 two mismatches over limit
        add_line(24'h9951, 16, 24'h0101, 8'hFF, 0, 0);
        add_bits(24'hFFFF, 16, 1'b1);                  run_line(2, 24'h0, 1, 1'b0);
        // R2 24-bit fixed code
        add_line(24'h1E3C1F, 24, 24'h0, 8'h5E, 2, 0);  run_line(3, 24'h0, 0, 1'b0);
        // R2 programmable codes
        add_line(24'hA7, 8, 24'h0, 8'h81, 2, 0);       run_line(4, 24'h0000A7, 0, 1'b0);
        add_line(24'hC3A4, 16, 24'h0, 8'h07, 2, 0);    run_line(5, 24'h00C3A4, 0, 1'b0);
        add_line(24'h7E0F81, 24, 24'h0, 8'h60, 1, 0);  run_line(6, 24'h7E0F81, 0, 1'b0);
        // R8 disabled selection never hits
        add_line(24'h27, 8, 24'h0, 8'h27, 2, 0);       run_line(7, 24'h0, 7, 1'b0);
        // R7 line without any code (alternating bits only)
        add_bits(24'hAAAAAA, 24, 1'b1);                run_line(0, 24'h0, 0, 1'b0);
        // R6 partial byte dropped, line end with a bit in the same cycle
        add_line(24'h27, 8, 24'h0, 8'h99, 1, 5);       run_line(0, 24'h0, 0, 1'b1);
        // R6 re-arm on the next line, R9 gaps covered in every line
        add_line(24'h27, 8, 24'h0, 8'h4B, 2, 3);       run_line(0, 24'h0, 0, 1'b0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule